// File: doc/BRIEF.md
# Gardner Timing Error Detector

This block measures symbol-timing error for a QPSK receiver whose I and Q rails arrive at two samples per symbol. Each sample strobe carries one I and one Q value and a flag telling whether it is an on-time sample or a mid-symbol sample. Every time a new on-time sample arrives, the block multiplies the latest mid-symbol sample of each rail by the change between the two latest on-time samples of that rail. It adds the two rail terms and emits the total once per symbol.

The total keeps full precision internally. It is then scaled down by an arithmetic right shift and clamped to a signed 10-bit range. A final offset of 512 turns it into an unsigned code that an external DAC can convert directly. The analog value produced by that DAC steers the oscillator that sets the receiver's sampling clock. The loop filter, the DAC and the oscillator sit outside this block.

Top module: `gardner_ted`

## Requirements
- R1: While reset is held and right after it is released, `err_vld_o` is 0 and `err_o` is 512, the code for zero error.
- R2: No error is reported until at least one on-time sample has been captured and at least one mid-symbol sample has been captured. An on-time strobe arriving before both have been seen only updates the history.
- R3: On a qualifying on-time strobe the raw error is mid_I*(new_I - old_I) + mid_Q*(new_Q - old_Q). Samples are signed two's complement. mid_X is the most recent mid-symbol sample of that rail, and old_X is the previous on-time sample of that rail.
- R4: The raw error is divided by 2^SHIFT_W using an arithmetic right shift, so the result is rounded toward minus infinity. With SHIFT_W=2, a raw error of -1 gives -1.
- R5: The scaled value is clamped to the range [-512, 511].
- R6: `err_o` equals the clamped value plus 512. Code 0 means the most negative error, 512 means zero, and 1023 means the most positive error.
- R7: `err_vld_o` is high for exactly the one cycle after the clock edge that accepted a qualifying on-time strobe. `err_o` changes only in that cycle and holds its value otherwise.
- R8: When `smp_vld_i` is low, the sample inputs and `on_time_i` are ignored. No pulse is produced and no history changes.
- R9: An accepted mid-symbol strobe (`on_time_i`=0) never produces a pulse. It only replaces the stored mid-symbol samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Sample strobe |
| on_time_i | input | 1 | 1 = on-time sample, 0 = mid-symbol sample |
| i_smp_i | input | SMP_W | I rail sample, signed |
| q_smp_i | input | SMP_W | Q rail sample, signed |
| err_o | output | OUT_W | Offset-binary error code for the DAC |
| err_vld_o | output | 1 | One-cycle pulse marking a new error code |

## Verification
The bench builds the block with SMP_W=6 and SHIFT_W=2, keeping OUT_W at 10. With six-bit samples, the full-scale products of both rails push the scaled error past 511 and below -512, so both clamp edges are reached with ordinary inputs. Small raw errors such as -1 make the rounding-toward-minus-infinity behaviour visible in the output code. About two thousand pseudo-random symbols are sent, mixed with repeated mid-symbol strobes, back-to-back on-time strobes and idle cycles carrying junk data. Together these cover the arming rule, the hold behaviour and the ignore rule.

// File: rtl/gted_pkg.sv
package gted_pkg;
  localparam int unsigned NUM_RAILS = 2;

  function automatic int unsigned term_width(int unsigned smp_w);
    return 2 * smp_w + 1;
  endfunction
endpackage

// File: rtl/gted_rail_hist.sv
module gted_rail_hist #(
  parameter int unsigned SMP_W = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_on_i,
  input  logic                    ld_mid_i,
  input  logic signed [SMP_W-1:0] smp_i,
  output logic signed [SMP_W-1:0] prev_o,
  output logic signed [SMP_W-1:0] mid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_o <= '0;
      mid_o  <= '0;
    end else begin
      if (ld_on_i)  prev_o <= smp_i;
      if (ld_mid_i) mid_o  <= smp_i;
    end
  end

  assert_one_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ld_on_i && ld_mid_i));
endmodule

// File: rtl/gted_rail_term.sv
module gted_rail_term #(
  parameter int unsigned SMP_W  = 10,
  parameter int unsigned TERM_W = 2 * SMP_W + 1
) (
  input  logic signed [SMP_W-1:0]  cur_i,
  input  logic signed [SMP_W-1:0]  prev_i,
  input  logic signed [SMP_W-1:0]  mid_i,
  output logic signed [TERM_W-1:0] term_o
);
  localparam int unsigned DIFF_W = SMP_W + 1;

  logic signed [DIFF_W-1:0] diff;

  always_comb begin
    diff   = DIFF_W'(cur_i) - DIFF_W'(prev_i);
    term_o = TERM_W'(mid_i) * TERM_W'(diff);
  end
endmodule

// File: rtl/gted_out_stage.sv
module gted_out_stage #(
  parameter int unsigned SUM_W   = 22,
  parameter int unsigned SHIFT_W = 10,
  parameter int unsigned OUT_W   = 10
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    vld_i,
  input  logic signed [SUM_W-1:0] sum_i,
  output logic [OUT_W-1:0]        code_o,
  output logic                    vld_o
);
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] MIN_V = -MAX_V - SUM_W'(1);
  localparam logic [OUT_W-1:0]        ZERO_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [SUM_W-1:0] scaled;
  logic signed [OUT_W-1:0] clamped;

  always_comb begin
    scaled = sum_i >>> SHIFT_W;
    if (scaled > MAX_V)      clamped = {1'b0, {(OUT_W-1){1'b1}}};
    else if (scaled < MIN_V) clamped = {1'b1, {(OUT_W-1){1'b0}}};
    else                     clamped = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o <= ZERO_CODE;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) code_o <= {~clamped[OUT_W-1], clamped[OUT_W-2:0]};
    end
  end

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(code_o));
endmodule

// File: rtl/gardner_ted.sv
module gardner_ted #(
  parameter int unsigned SMP_W   = 10,
  parameter int unsigned SHIFT_W = 10,
  parameter int unsigned OUT_W   = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             smp_vld_i,
  input  logic             on_time_i,
  input  logic [SMP_W-1:0] i_smp_i,
  input  logic [SMP_W-1:0] q_smp_i,
  output logic [OUT_W-1:0] err_o,
  output logic             err_vld_o
);
  import gted_pkg::*;

  localparam int unsigned TERM_W = term_width(SMP_W);
  localparam int unsigned SUM_W  = TERM_W + $clog2(NUM_RAILS);

  logic signed [SMP_W-1:0]  rail_smp  [NUM_RAILS];
  logic signed [SMP_W-1:0]  rail_prev [NUM_RAILS];
  logic signed [SMP_W-1:0]  rail_mid  [NUM_RAILS];
  logic signed [TERM_W-1:0] rail_term [NUM_RAILS];
  logic signed [SUM_W-1:0]  err_sum;
  logic ld_on, ld_mid, have_prev, have_mid, fire;

  assign rail_smp[0] = i_smp_i;
  assign rail_smp[1] = q_smp_i;
  assign ld_on  = smp_vld_i && on_time_i;
  assign ld_mid = smp_vld_i && !on_time_i;
  assign fire   = ld_on && have_prev && have_mid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev <= 1'b0;
      have_mid  <= 1'b0;
    end else begin
      if (ld_on)  have_prev <= 1'b1;
      if (ld_mid) have_mid  <= 1'b1;
    end
  end

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    gted_rail_hist #(.SMP_W(SMP_W)) i_hist (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ld_on_i (ld_on),
      .ld_mid_i(ld_mid),
      .smp_i   (rail_smp[r]),
      .prev_o  (rail_prev[r]),
      .mid_o   (rail_mid[r])
    );
    gted_rail_term #(.SMP_W(SMP_W), .TERM_W(TERM_W)) i_term (
      .cur_i (rail_smp[r]),
      .prev_i(rail_prev[r]),
      .mid_i (rail_mid[r]),
      .term_o(rail_term[r])
    );
  end

  always_comb begin
    err_sum = '0;
    for (int r = 0; r < NUM_RAILS; r++) err_sum = err_sum + SUM_W'(rail_term[r]);
  end

  gted_out_stage #(.SUM_W(SUM_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)) i_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (fire),
    .sum_i (err_sum),
    .code_o(err_o),
    .vld_o (err_vld_o)
  );

  assert_armed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |-> $past(have_prev && have_mid));
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_vld_i |=> !err_vld_o);
  assert_mid_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_vld_i && !on_time_i) |=> !err_vld_o);
  assert_pulse_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_vld_o |-> $past(smp_vld_i && on_time_i));
endmodule

// File: tb/test_gardner_ted.sv
module test_gardner_ted;
  localparam int SMP_W = 6;
  localparam int SHIFT_W = 2;
  localparam int OUT_W = 10;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, ot = 1'b0;
  logic [SMP_W-1:0] i_s = '0, q_s = '0;
  logic [OUT_W-1:0] err;
  logic err_vld;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // bench model state
  int m_pi = 0, m_pq = 0, m_mi = 0, m_mq = 0;
  bit m_hp = 0, m_hm = 0;
  int last_code = 512;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  gardner_ted #(.SMP_W(SMP_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)) i_gardner_ted (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(vld), .on_time_i(ot),
    .i_smp_i(i_s), .q_smp_i(q_s), .err_o(err), .err_vld_o(err_vld));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(int e);
    int s = e >>> SHIFT_W;
    if (s > 511) s = 511;
    if (s < -512) s = -512;
    return s + 512;
  endfunction

  function automatic int rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr[SMP_W-1:0]));
  endfunction

  task automatic send(input bit on, input int iv, input int qv, input string tag);
    bit fires;
    int expc;
    @(negedge clk);
    chk(err_vld == 1'b0, "R7 pulse width", int'(err_vld), 0);
    vld = 1'b1; ot = on; i_s = SMP_W'(iv); q_s = SMP_W'(qv);
    fires = on && m_hp && m_hm;
    expc = fires ? exp_code(m_mi*(iv - m_pi) + m_mq*(qv - m_pq)) : last_code;
    @(negedge clk);
    vld = 1'b0;
    if (fires) chk(err_vld == 1'b1, {tag, " R7 pulse"}, int'(err_vld), 1);
    else if (!on) chk(err_vld == 1'b0, "R9 mid no pulse", int'(err_vld), 0);
    else chk(err_vld == 1'b0, "R2 not armed", int'(err_vld), 0);
    chk(int'(err) == expc, fires ? {tag, " R3 R6 code"} : "R7 hold", int'(err), expc);
    last_code = expc;
    if (on) begin m_pi = iv; m_pq = qv; m_hp = 1; end
    else begin m_mi = iv; m_mq = qv; m_hm = 1; end
  endtask

  task automatic idle_junk(input bit on, input int iv, input int qv);
    @(negedge clk);
    vld = 1'b0; ot = on; i_s = SMP_W'(iv); q_s = SMP_W'(qv);
    @(negedge clk);
    chk(err_vld == 1'b0, "R8 ignored strobe-less pulse", int'(err_vld), 0);
    chk(int'(err) == last_code, "R8 ignored code", int'(err), last_code);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(err_vld == 1'b0, "R1 reset vld", int'(err_vld), 0);
    chk(int'(err) == 512, "R1 reset code", int'(err), 512);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(err) == 512, "R1 after release", int'(err), 512);
    // arming: on-time, on-time (no mid yet), then mid, then on-time fires
    send(1, 5, -3, "R2");
    send(1, 7, 2, "R2");
    send(0, 4, 4, "R9");
    send(1, -2, 9, "R2 first");
    // R4 floor: raw -1
    send(0, 1, 0, "R4");
    send(1, 0, 0, "R4 prep");
    send(1, -1, 0, "R4 floor");
    // R5 positive clamp: mid -32, diff -63 on both rails
    send(1, 31, 31, "R5");
    send(0, -32, -32, "R5");
    send(1, -32, -32, "R5 high clamp");
    chk(int'(err) == 1023, "R5 top code", int'(err), 1023);
    // R5 negative clamp
    send(1, 31, 31, "R5 low clamp");
    chk(int'(err) == 0, "R5 bottom code", int'(err), 0);
    // R8 junk while strobe low, then confirm history untouched
    idle_junk(1, -20, 17);
    idle_junk(0, 13, -9);
    send(1, 3, 3, "R8 history kept");
    // pseudo-random sweep with varied ordering
    for (int k = 0; k < 2000; k++) begin
      if (k % 7 == 3) send(0, rnd(), rnd(), "R9 repeat mid");
      if (k % 11 == 5) idle_junk(k[0], rnd(), rnd());
      send(0, rnd(), rnd(), "R9 sweep mid");
      send(1, rnd(), rnd(), "R3 sweep");
      if (k % 13 == 2) send(1, rnd(), rnd(), "R3 back-to-back");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule